// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This is a purely combinational unit for the one-operand instruction group of a small 16-bit processor. The operand arrives already fetched. The unit returns the new value and the updated N, Z, V and C flags in the same cycle. Address generation, memory traffic and the write of the result are left to the surrounding datapath.

A byte/word select narrows most operations to the low lane. In the low lane, bit 7 is the sign bit and bits 7:0 are the value. The upper byte of the result then carries the operand's upper byte unchanged, so a register write keeps that byte intact. Byte swap and sign extension always work on the whole word.

Each operation follows its own rule for V and C. The rules include fixed-value overflow tests, carry only on a wrap, and V formed as N xor C after a shift or rotate. An operation code with no definition raises a flag. In that case the operand passes through unchanged and the flags are kept.

Top module: `sop_alu`

## Requirements
- R1: Flags are packed as bit 3 N, bit 2 Z, bit 1 V, bit 0 C on both flag ports. Code 0 (clear) gives a zero value and flags 0100.
- R2: Code 1 (complement) inverts the value. N and Z follow the result, V is cleared and C is set.
- R3: Codes 2 (increment) and 3 (decrement) keep C. For increment, V is set only when the result is the most negative value (0x8000 word, 0x80 byte). For decrement, V is set only when the result is the most positive value (0x7FFF word, 0x7F byte).
- R4: Code 4 (negate) gives the two's complement. V is set when the result is the most negative value, and C is set when the result is nonzero.
- R5: Code 5 (add carry) adds C. V is set only when the value steps from most positive to most negative. C is set only when it steps from all ones to zero.
- R6: Code 6 (subtract carry) subtracts C. V is set only when the value steps from most negative to most positive. C is set only when it steps from zero to all ones.
- R7: Codes 8 (rotate right) and 9 (rotate left) rotate through C. C takes the bit shifted out, and V is the new N xor the new C.
- R8: Codes 10 (arithmetic shift right, sign bit kept) and 11 (shift left, zero in) set C to the bit shifted out and V to the new N xor the new C.
- R9: Code 7 (test) returns the operand. N and Z follow the operand, and V and C are cleared.
- R10: Code 12 (byte swap) exchanges the two bytes of the full word in either mode. N and Z follow the low byte of the result, and V and C are cleared.
- R11: Code 13 (sign extend) gives all ones if the incoming N is set and zero otherwise, on the full word in either mode. Z follows the result, N is the incoming N, V is cleared and C is kept.
- R12: With byte_mode high, codes 0 to 11 act on bits 7:0 with bit 7 as sign. Bits 15:8 of the result equal bits 15:8 of the operand.
- R13: Codes 14 and 15 are undefined. They raise illegal_op, return the operand unchanged and leave the flags as they came in. Every defined code holds illegal_op low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects the low-byte lane |
| operand | input | 16 | Operand value |
| flags_in | input | 4 | Current N, Z, V, C |
| result | output | 16 | Computed value |
| flags_out | output | 4 | New N, Z, V, C |
| illegal_op | output | 1 | Undefined operation code |

## Verification
The checks assume that the inputs are stable and fully known whenever the outputs are looked at. A glitch-free settle of the combinational path is taken as given. No timing across cycles is implied. The bench changes the inputs only on the falling clock edge and reads the outputs one nanosecond later, so every comparison sees settled values. Each stimulus pattern uses only the sixteen codes of the 4-bit select and never drives X or Z.

// File: rtl/sop_alu.sv
module sop_alu #(
  parameter int WORD_W = 16,
  parameter int OP_W   = 4
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic              byte_mode,
  input  logic [WORD_W-1:0] operand,
  input  logic [3:0]        flags_in,
  output logic [WORD_W-1:0] result,
  output logic [3:0]        flags_out,
  output logic              illegal_op
);
  localparam int HALF = WORD_W / 2;
  localparam logic [WORD_W-1:0] ONES     = '1;
  localparam logic [WORD_W-1:0] LOW_ONES = ONES >> HALF;
  localparam logic [WORD_W-1:0] W_SIGN   = ONES ^ (ONES >> 1);
  localparam logic [WORD_W-1:0] B_SIGN   = LOW_ONES ^ (LOW_ONES >> 1);

  localparam logic [OP_W-1:0] OP_CLR = 0,  OP_COM = 1,  OP_INC = 2,  OP_DEC = 3;
  localparam logic [OP_W-1:0] OP_NEG = 4,  OP_ADC = 5,  OP_SBC = 6,  OP_TST = 7;
  localparam logic [OP_W-1:0] OP_ROR = 8,  OP_ROL = 9,  OP_ASR = 10, OP_ASL = 11;
  localparam logic [OP_W-1:0] OP_SWP = 12, OP_SXT = 13;

  logic              n_i, z_i, v_i, c_i;
  logic [WORD_W-1:0] mask, sgn, opv, cy, r;
  logic              shout, full, ill, rn, rz;
  logic [3:0]        fo;

  assign {n_i, z_i, v_i, c_i} = flags_in;
  assign mask = byte_mode ? LOW_ONES : ONES;
  assign sgn  = byte_mode ? B_SIGN : W_SIGN;
  assign opv  = operand & mask;
  assign cy   = WORD_W'(c_i);

  always_comb begin
    r     = opv;
    shout = 1'b0;
    full  = 1'b0;
    ill   = 1'b0;
    case (op_sel)
      OP_CLR: r = '0;
      OP_COM: r = ~opv & mask;
      OP_INC: r = (opv + WORD_W'(1)) & mask;
      OP_DEC: r = (opv - WORD_W'(1)) & mask;
      OP_NEG: r = (WORD_W'(0) - opv) & mask;
      OP_ADC: r = (opv + cy) & mask;
      OP_SBC: r = (opv - cy) & mask;
      OP_TST: r = opv;
      OP_ROR: begin r = (opv >> 1) | (c_i ? sgn : '0);  shout = opv[0]; end
      OP_ROL: begin r = ((opv << 1) | cy) & mask;       shout = |(opv & sgn); end
      OP_ASR: begin r = (opv >> 1) | (opv & sgn);       shout = opv[0]; end
      OP_ASL: begin r = (opv << 1) & mask;              shout = |(opv & sgn); end
      OP_SWP: begin full = 1'b1; r = {operand[HALF-1:0], operand[WORD_W-1:HALF]}; end
      OP_SXT: begin full = 1'b1; r = n_i ? ONES : '0; end
      default: ill = 1'b1;
    endcase
  end

  assign rn = (op_sel == OP_SWP) ? r[HALF-1] :
              full               ? r[WORD_W-1] : |(r & sgn);
  assign rz = (op_sel == OP_SWP) ? (r[HALF-1:0] == '0) : (r == '0);

  always_comb begin
    case (op_sel)
      OP_CLR: fo = 4'b0100;
      OP_COM: fo = {rn, rz, 1'b0, 1'b1};
      OP_INC: fo = {rn, rz, r == sgn, c_i};
      OP_DEC: fo = {rn, rz, r == (mask ^ sgn), c_i};
      OP_NEG: fo = {rn, rz, r == sgn, r != '0};
      OP_ADC: fo = {rn, rz, (opv == (mask ^ sgn)) && (r == sgn),
                            (opv == mask) && (r == '0)};
      OP_SBC: fo = {rn, rz, (opv == sgn) && (r == (mask ^ sgn)),
                            (opv == '0) && (r == mask)};
      OP_TST: fo = {rn, rz, 1'b0, 1'b0};
      OP_ROR, OP_ROL, OP_ASR, OP_ASL: fo = {rn, rz, rn ^ shout, shout};
      OP_SWP: fo = {rn, rz, 1'b0, 1'b0};
      OP_SXT: fo = {rn, rz, 1'b0, c_i};
      default: fo = flags_in;
    endcase
  end

  assign result     = ill ? operand : full ? r : ((operand & ~mask) | r);
  assign flags_out  = fo;
  assign illegal_op = ill;
endmodule

module sop_alu_chk #(
  parameter int WORD_W = 16,
  parameter int OP_W   = 4
) (
  input logic [OP_W-1:0]   op_sel,
  input logic              byte_mode,
  input logic [WORD_W-1:0] operand,
  input logic [3:0]        flags_in,
  input logic [WORD_W-1:0] result,
  input logic [3:0]        flags_out,
  input logic              illegal_op
);
  localparam int HALF = WORD_W / 2;

  always_comb begin
    // R1
    if (op_sel == 0)
      clear_flags_chk: assert (flags_out == 4'b0100);
    // R3
    if (op_sel == 2 || op_sel == 3)
      incdec_keep_c_chk: assert (flags_out[0] == flags_in[0]);
    // R7
    if (op_sel == 8 || op_sel == 9)
      rotate_v_chk: assert (flags_out[1] == (flags_out[3] ^ flags_out[0]));
    // R8
    if (op_sel == 10 || op_sel == 11)
      shift_v_chk: assert (flags_out[1] == (flags_out[3] ^ flags_out[0]));
    // R12
    if (byte_mode && op_sel < 12)
      upper_byte_kept_chk: assert (result[WORD_W-1:HALF] == operand[WORD_W-1:HALF]);
    // R13
    if (op_sel >= 14)
      illegal_hold_chk: assert (illegal_op && flags_out == flags_in && result == operand);
    // R13
    if (op_sel < 14)
      legal_no_flag_chk: assert (!illegal_op);
    // R10
    if (op_sel == 12)
      swap_vc_clear_chk: assert (flags_out[1:0] == 2'b00);
  end
endmodule

bind sop_alu sop_alu_chk #(.WORD_W(WORD_W), .OP_W(OP_W)) u_chk (
  .op_sel(op_sel), .byte_mode(byte_mode), .operand(operand), .flags_in(flags_in),
  .result(result), .flags_out(flags_out), .illegal_op(illegal_op)
);

// File: tb/sop_alu_tb.sv
module sop_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] operand = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic        illegal_op;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sop_alu u_dut (
    .op_sel(op_sel), .byte_mode(byte_mode), .operand(operand), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .illegal_op(illegal_op)
  );

  task automatic run(input string tag, input logic [3:0] op, input logic byt,
                     input logic [15:0] opnd, input logic [3:0] fl,
                     input logic [15:0] exp_r, input logic [3:0] exp_f,
                     input logic exp_ill);
    @(negedge clk);
    op_sel = op; byte_mode = byt; operand = opnd; flags_in = fl;
    #1;
    checks++;
    if (result !== exp_r || flags_out !== exp_f || illegal_op !== exp_ill) begin
      errors++;
      $display("FAIL %s: op=%0d byte=%0b opnd=%h got r=%h f=%b ill=%b exp r=%h f=%b ill=%b",
               tag, op, byt, opnd, result, flags_out, illegal_op, exp_r, exp_f, exp_ill);
    end
  endtask

  task automatic t_clear();
    run("R1", 0, 0, 16'h1234, 4'b1011, 16'h0000, 4'b0100, 0);
    run("R1", 0, 0, 16'hFFFF, 4'b0000, 16'h0000, 4'b0100, 0);
  endtask

  task automatic t_complement();
    run("R2", 1, 0, 16'h00FF, 4'b0000, 16'hFF00, 4'b1001, 0);
    run("R2", 1, 0, 16'hFFFF, 4'b0010, 16'h0000, 4'b0101, 0);
  endtask

  task automatic t_incdec();
    run("R3", 2, 0, 16'h7FFF, 4'b0001, 16'h8000, 4'b1011, 0);
    run("R3", 2, 0, 16'hFFFF, 4'b0000, 16'h0000, 4'b0100, 0);
    run("R3", 3, 0, 16'h8000, 4'b0000, 16'h7FFF, 4'b0010, 0);
    run("R3", 3, 0, 16'h0001, 4'b0001, 16'h0000, 4'b0101, 0);
    run("R3", 3, 1, 16'h0080, 4'b0000, 16'h007F, 4'b0010, 0);
  endtask

  task automatic t_negate();
    run("R4", 4, 0, 16'h0001, 4'b0000, 16'hFFFF, 4'b1001, 0);
    run("R4", 4, 0, 16'h8000, 4'b0000, 16'h8000, 4'b1011, 0);
    run("R4", 4, 0, 16'h0000, 4'b1111, 16'h0000, 4'b0100, 0);
  endtask

  task automatic t_adc();
    run("R5", 5, 0, 16'h7FFF, 4'b0001, 16'h8000, 4'b1010, 0);
    run("R5", 5, 0, 16'hFFFF, 4'b0001, 16'h0000, 4'b0101, 0);
    run("R5", 5, 0, 16'h1234, 4'b0000, 16'h1234, 4'b0000, 0);
  endtask

  task automatic t_sbc();
    run("R6", 6, 0, 16'h8000, 4'b0001, 16'h7FFF, 4'b0010, 0);
    run("R6", 6, 0, 16'h0000, 4'b0001, 16'hFFFF, 4'b1001, 0);
  endtask

  task automatic t_rotate();
    run("R7", 8, 0, 16'h0001, 4'b0000, 16'h0000, 4'b0111, 0);
    run("R7", 8, 0, 16'h0002, 4'b0001, 16'h8001, 4'b1010, 0);
    run("R7", 9, 0, 16'h8000, 4'b0000, 16'h0000, 4'b0111, 0);
    run("R7", 9, 0, 16'h4000, 4'b0001, 16'h8001, 4'b1010, 0);
  endtask

  task automatic t_shift();
    run("R8", 10, 0, 16'h8001, 4'b0000, 16'hC000, 4'b1001, 0);
    run("R8", 10, 0, 16'h0002, 4'b0001, 16'h0001, 4'b0000, 0);
    run("R8", 11, 0, 16'h4000, 4'b0000, 16'h8000, 4'b1010, 0);
    run("R8", 11, 0, 16'hC000, 4'b0000, 16'h8000, 4'b1001, 0);
  endtask

  task automatic t_test();
    run("R9", 7, 0, 16'h8000, 4'b0011, 16'h8000, 4'b1000, 0);
    run("R9", 7, 0, 16'h0000, 4'b1011, 16'h0000, 4'b0100, 0);
  endtask

  task automatic t_swap();
    run("R10", 12, 0, 16'h12F0, 4'b0011, 16'hF012, 4'b0000, 0);
    run("R10", 12, 0, 16'h8000, 4'b0000, 16'h0080, 4'b1000, 0);
    run("R10", 12, 0, 16'h00FF, 4'b0000, 16'hFF00, 4'b0100, 0);
    run("R10", 12, 1, 16'h12F0, 4'b0000, 16'hF012, 4'b0000, 0);
  endtask

  task automatic t_sxt();
    run("R11", 13, 0, 16'h1234, 4'b1001, 16'hFFFF, 4'b1001, 0);
    run("R11", 13, 0, 16'h1234, 4'b0011, 16'h0000, 4'b0101, 0);
    run("R11", 13, 1, 16'h1234, 4'b1000, 16'hFFFF, 4'b1000, 0);
  endtask

  task automatic t_byte();
    run("R12", 2, 1, 16'hAB7F, 4'b0000, 16'hAB80, 4'b1010, 0);
    run("R12", 4, 1, 16'h5501, 4'b0000, 16'h55FF, 4'b1001, 0);
    run("R12", 0, 1, 16'h12FF, 4'b0000, 16'h1200, 4'b0100, 0);
    run("R12", 11, 1, 16'h0040, 4'b0000, 16'h0080, 4'b1010, 0);
    run("R12", 8, 1, 16'h3400, 4'b0001, 16'h3480, 4'b1010, 0);
    run("R12", 5, 1, 16'h00FF, 4'b0001, 16'h0000, 4'b0101, 0);
    run("R12", 6, 1, 16'h0080, 4'b0001, 16'h007F, 4'b0010, 0);
  endtask

  task automatic t_illegal();
    run("R13", 14, 0, 16'h5A5A, 4'b1010, 16'h5A5A, 4'b1010, 1);
    run("R13", 15, 1, 16'hA5A5, 4'b0101, 16'hA5A5, 4'b0101, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    run("R1", 0, 0, 16'h0000, 4'b0000, 16'h0000, 4'b0100, 0);
    t_clear();
    t_complement();
    t_incdec();
    t_negate();
    t_adc();
    t_sbc();
    t_rotate();
    t_shift();
    t_test();
    t_swap();
    t_sxt();
    t_byte();
    t_illegal();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule